// File: doc/BRIEF.md
# Hamming ECC compare-and-correct unit

This unit works on one chunk of flash data protected by a 24-bit single-error-correcting Hamming code. It receives two codes: the one read back from the spare area of the page, and the one recomputed over the chunk as it was read. The two codes are XORed into a syndrome. The unit classifies the result from that syndrome alone, and for a recoverable data error it also produces the byte offset inside the chunk and a one-hot bit mask. The surrounding logic XORs this mask into its buffered copy of that byte.

A result is produced for every cycle in which the valid strobe is high. It is registered, appears on the cycle after the strobe, and is marked by a one-cycle done pulse. The outputs hold their values until the next strobe. The chunk length is a parameter with a default of 512 bytes. The syndrome half width is also a parameter: the upper half holds the byte offset and the 3-bit bit index, and the lower half holds their complement.

Top module: `hecc_fix_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_done is 0, out_status is 00, out_byte is 0 and out_mask is 0.
- R2: out_done is 1 on exactly the cycle that follows a cycle with in_valid high, and 0 on every other cycle; strobes on consecutive cycles give results on consecutive cycles.
- R3: When the two codes are equal (zero syndrome), out_status is 00 (clean), out_byte is 0 and out_mask is 0.
- R4: When the syndrome's upper 12 bits XOR its lower 12 bits gives all ones, and syndrome bits 23:15 are below the chunk length, out_status is 01 (data corrected), out_byte equals syndrome bits 23:15, and out_mask has only the bit selected by syndrome bits 14:12 set. XORing the mask into that byte restores the original data.
- R5: A syndrome that passes the complement test of R4 but whose byte offset (bits 23:15) is at or above the chunk length gives out_status 11 (uncorrectable), with out_byte 0 and out_mask 0.
- R6: A syndrome with exactly one bit set is a flipped bit in the code itself: out_status is 10, out_byte is 0, out_mask is 0, and the chunk data is left untouched.
- R7: Any other nonzero syndrome, including any two-bit syndrome, gives out_status 11 with out_byte 0 and out_mask 0.
- R8: On a cycle without a strobe, out_status, out_byte and out_mask keep the values they had on the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking a code pair to evaluate |
| code_stored | input | 24 | Code read from the spare area, byte 0 in bits 7:0 |
| code_calc | input | 24 | Code recomputed over the chunk, byte 0 in bits 7:0 |
| out_done | output | 1 | One-cycle pulse marking a new result |
| out_status | output | 2 | 00 clean, 01 data corrected, 10 code bit flipped, 11 uncorrectable |
| out_byte | output | 9 | Byte offset of the bad bit within the chunk |
| out_mask | output | 8 | One-hot bit to flip in that byte, zero unless status is 01 |

## Verification
The embedded properties rely on in_valid being a clean 0/1 level driven once per cycle. They also rely on code inputs that are stable across the sampling edge, because a result is only tied to the codes present on the strobe cycle. The stimulus changes inputs only on the falling edge and always pairs a random base code with a deliberately built syndrome. The syndromes cover the three error classes, the chunk-length boundary and back-to-back strobes, and idle gaps between strobes exercise the hold behaviour. The bench runs with a reduced chunk length, so that offsets past the chunk can actually occur within the 9-bit field.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN      = 2'b00,
    ST_DATA_FIXED = 2'b01,
    ST_CODE_FLIP  = 2'b10,
    ST_UNCORR     = 2'b11
  } hecc_status_e;

  localparam int BIT_IDX_W = 3;
  localparam int BYTE_BITS = 1 << BIT_IDX_W;

endpackage

// File: rtl/hecc_syndrome.sv
module hecc_syndrome #(
  parameter int CODE_W = 24
) (
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  output logic [CODE_W-1:0] syn
);
  assign syn = code_a ^ code_b;
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
  import hecc_pkg::*;
#(
  parameter int HALF_W      = 12,
  parameter int CHUNK_BYTES = 512,
  localparam int CODE_W     = 2 * HALF_W,
  localparam int BYTE_W     = HALF_W - BIT_IDX_W
) (
  input  logic [CODE_W-1:0]    syn,
  output hecc_status_e         status,
  output logic [BYTE_W-1:0]    byte_ofs,
  output logic [BIT_IDX_W-1:0] bit_idx
);
  localparam logic [BYTE_W:0] LIMIT = (BYTE_W+1)'(CHUNK_BYTES);

  logic [HALF_W-1:0]    hi_half, lo_half;
  logic                 is_zero, is_compl, is_single, in_range;
  logic [BYTE_W-1:0]    raw_ofs;
  logic [BIT_IDX_W-1:0] raw_bit;

  assign hi_half   = syn[CODE_W-1:HALF_W];
  assign lo_half   = syn[HALF_W-1:0];
  assign raw_ofs   = hi_half[HALF_W-1:BIT_IDX_W];
  assign raw_bit   = hi_half[BIT_IDX_W-1:0];
  assign is_zero   = (syn == '0);
  assign is_compl  = ((hi_half ^ lo_half) == {HALF_W{1'b1}});
  assign is_single = !is_zero && ((syn & (syn - 1'b1)) == '0);
  assign in_range  = ({1'b0, raw_ofs} < LIMIT);

  always_comb begin
    status   = ST_UNCORR;
    byte_ofs = '0;
    bit_idx  = '0;
    if (is_zero) begin
      status = ST_CLEAN;
    end else if (is_compl) begin
      if (in_range) begin
        status   = ST_DATA_FIXED;
        byte_ofs = raw_ofs;
        bit_idx  = raw_bit;
      end
    end else if (is_single) begin
      status = ST_CODE_FLIP;
    end
  end
endmodule

// File: rtl/hecc_mask_dec.sv
module hecc_mask_dec #(
  parameter int IDX_W     = 3,
  localparam int MASK_W   = 1 << IDX_W
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [MASK_W-1:0] mask
);
  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    localparam logic [IDX_W-1:0] K = IDX_W'(i);
    assign mask[i] = en && (idx == K);
  end
endmodule

// File: rtl/hecc_fix_unit.sv
module hecc_fix_unit
  import hecc_pkg::*;
#(
  parameter int HALF_W      = 12,
  parameter int CHUNK_BYTES = 512,
  localparam int CODE_W     = 2 * HALF_W,
  localparam int BYTE_W     = HALF_W - BIT_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [CODE_W-1:0]    code_stored,
  input  logic [CODE_W-1:0]    code_calc,
  output logic                 out_done,
  output logic [1:0]           out_status,
  output logic [BYTE_W-1:0]    out_byte,
  output logic [BYTE_BITS-1:0] out_mask
);
  logic [CODE_W-1:0]    syn;
  hecc_status_e         cls_status;
  logic [BYTE_W-1:0]    cls_byte;
  logic [BIT_IDX_W-1:0] cls_bit;
  logic [BYTE_BITS-1:0] cls_mask;

  hecc_syndrome #(.CODE_W(CODE_W)) u_syn (
    .code_a(code_stored), .code_b(code_calc), .syn(syn)
  );

  hecc_classify #(.HALF_W(HALF_W), .CHUNK_BYTES(CHUNK_BYTES)) u_cls (
    .syn(syn), .status(cls_status), .byte_ofs(cls_byte), .bit_idx(cls_bit)
  );

  hecc_mask_dec #(.IDX_W(BIT_IDX_W)) u_dec (
    .en(cls_status == ST_DATA_FIXED), .idx(cls_bit), .mask(cls_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_done   <= 1'b0;
      out_status <= ST_CLEAN;
      out_byte   <= '0;
      out_mask   <= '0;
    end else begin
      out_done <= in_valid;
      if (in_valid) begin
        out_status <= cls_status;
        out_byte   <= cls_byte;
        out_mask   <= cls_mask;
      end
    end
  end

  // R2: done pulse tracks the strobe by exactly one cycle
  a_r2_done_after_valid: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_done);
  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_done);

  // R3: equal codes give a clean result
  a_r3_clean_on_equal: assert property (@(posedge clk) disable iff (rst)
    (in_valid && code_stored == code_calc) |=> (out_status == ST_CLEAN));

  // R4: a data correction carries one mask bit and an offset inside the chunk
  a_r4_mask_onehot: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_status == ST_DATA_FIXED) |-> $onehot(out_mask));
  a_r4_offset_in_chunk: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_status == ST_DATA_FIXED) |-> ({1'b0, out_byte} < (BYTE_W+1)'(CHUNK_BYTES)));

  // R6, R7: no mask and no offset for any other class
  a_r6_quiet_otherwise: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_status != ST_DATA_FIXED) |-> (out_mask == '0 && out_byte == '0));

  // R8: result held while no strobe arrives
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_status) && $stable(out_byte) && $stable(out_mask)));
endmodule

// File: tb/sim_hecc_fix_unit.sv
module sim_hecc_fix_unit;
  localparam int HW = 12;
  localparam int CB = 320;
  localparam int CW = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] code_stored = '0;
  logic [23:0] code_calc = '0;
  logic        out_done;
  logic [1:0]  out_status;
  logic [8:0]  out_byte;
  logic [7:0]  out_mask;

  hecc_fix_unit #(.HALF_W(HW), .CHUNK_BYTES(CB)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .code_stored(code_stored), .code_calc(code_calc),
    .out_done(out_done), .out_status(out_status),
    .out_byte(out_byte), .out_mask(out_mask)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;
  bit model_live = 0;

  logic [7:0] golden [CB];
  logic [7:0] buffer [CB];

  // reference model state
  logic       e_done;
  logic [1:0] e_st;
  logic [8:0] e_byte;
  logic [7:0] e_mask;
  logic       e_r5;

  function automatic logic [19:0] ref_eval(input logic [23:0] s);
    int sv, up, lo, b, k;
    logic [1:0] st;
    logic [8:0] by;
    logic [7:0] m;
    logic r5;
    sv = int'(s);
    up = (sv >> 12) & 'hfff;
    lo = sv & 'hfff;
    st = 2'b11; by = '0; m = '0; r5 = 1'b0;
    if (sv == 0) st = 2'b00;
    else if ((up ^ lo) == 'hfff) begin
      b = sv >> 15;
      k = (sv >> 12) & 7;
      if (b < CB) begin st = 2'b01; by = 9'(b); m = 8'(1 << k); end
      else r5 = 1'b1;
    end else if ((sv & (sv - 1)) == 0) st = 2'b10;
    return {r5, st, by, m};
  endfunction

  always @(posedge clk) begin
    logic [19:0] r;
    model_live <= 1'b1;
    if (rst) begin
      e_done <= 0; e_st <= 0; e_byte <= 0; e_mask <= 0; e_r5 <= 0;
    end else begin
      e_done <= in_valid;
      if (in_valid) begin
        r = ref_eval(code_stored ^ code_calc);
        e_r5 <= r[19]; e_st <= r[18:17]; e_byte <= r[16:8]; e_mask <= r[7:0];
      end
    end
  end

  function automatic string tag_of();
    if (rst) return "R1";
    if (!e_done) return "R8";
    case (e_st)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R6";
      default: return e_r5 ? "R5" : "R7";
    endcase
  endfunction

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (model_live && !finished) begin
      n_checks++;
      if (out_done !== e_done) begin
        n_fail++;
        $display("FAIL R2 done: actual %0b expected %0b", out_done, e_done);
      end
      n_checks++;
      if (out_status !== e_st || out_byte !== e_byte || out_mask !== e_mask) begin
        n_fail++;
        $display("FAIL %s result: actual st=%b byte=%0d mask=%b expected st=%b byte=%0d mask=%b",
                 tag_of(), out_status, out_byte, out_mask, e_st, e_byte, e_mask);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  function automatic logic [23:0] data_syn(input int b, input int k);
    logic [11:0] up;
    up = {9'(b), 3'(k)};
    return {up, ~up};
  endfunction

  task automatic send(input logic [23:0] syn);
    logic [23:0] base;
    base = 24'($urandom);
    @(negedge clk);
    code_stored = base;
    code_calc = base ^ syn;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // apply the reported fix to the buffer and compare with the golden copy
  task automatic check_buffer(input string tag);
    int bad;
    if (out_done && out_status == 2'b01) buffer[out_byte] = buffer[out_byte] ^ out_mask;
    bad = 0;
    for (int i = 0; i < CB; i++) if (buffer[i] !== golden[i]) bad++;
    n_checks++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s buffer: actual %0d bad bytes expected 0", tag, bad);
    end
    for (int i = 0; i < CB; i++) buffer[i] = golden[i];
  endtask

  task automatic data_flip(input int b, input int k);
    buffer[b] = buffer[b] ^ 8'(1 << k);
    send(data_syn(b, k));
    check_buffer("R4");
  endtask

  initial begin
    for (int i = 0; i < CB; i++) begin
      golden[i] = 8'($urandom);
      buffer[i] = golden[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R3: equal codes
    for (int i = 0; i < 5; i++) send(24'h0);

    // R4: single data-bit flips, including both ends of the chunk
    data_flip(0, 0);
    data_flip(1, 7);
    data_flip(CB - 1, 3);
    data_flip(100, 5);
    for (int i = 0; i < 12; i++) data_flip(int'($urandom_range(CB - 1)), int'($urandom_range(7)));

    // R5: complementary pattern pointing past the chunk
    send(data_syn(CB, 2));
    send(data_syn(400, 6));
    send(data_syn(511, 7));

    // R6: a flipped bit in the code itself, data left alone
    for (int j = 0; j < CW; j++) begin
      send(24'(1) << j);
      check_buffer("R6");
    end

    // R7: double flips and random multi-bit damage
    for (int i = 0; i < 30; i++) begin
      int a, c;
      a = int'($urandom_range(CW - 1));
      c = (a + 1 + int'($urandom_range(CW - 2))) % CW;
      send((24'(1) << a) | (24'(1) << c));
    end
    for (int i = 0; i < 15; i++) send(24'($urandom));

    // R2: back-to-back strobes
    @(negedge clk);
    code_stored = 24'h123456; code_calc = 24'h123456 ^ data_syn(7, 1); in_valid = 1'b1;
    @(negedge clk);
    code_stored = 24'h0; code_calc = 24'h000100; in_valid = 1'b1;
    @(negedge clk);
    code_calc = 24'h000300;
    @(negedge clk);
    in_valid = 1'b0;

    // R8: idle cycles hold the last result
    repeat (6) @(negedge clk);
    send(data_syn(42, 4));
    repeat (5) @(negedge clk);

    // R1: reset again clears everything
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule